// File: doc/BRIEF.md
# Fuse-Gated Authentication Message Assembler

This block prepares the identity and secret fields that feed a keyed-digest engine, and it decides whether a request to program the secret fuses may go ahead. Constant identity parts come from ROM ports and the programmable parts come from fuse ports. A single one-time flag, the guard fuse, controls both jobs. While the guard is still unburned, every fuse-derived bit placed in the message reads as one and secure-burn requests are passed to the fuse programmer. Once the guard is burned, the real fuse contents go into the message and every secure-burn request is refused.

A digest request carries a flag that selects whether the 48-bit serial number takes part. When the serial number is left out, its slot is filled with zeros so the message keeps the same length. The assembled fields appear together, for one cycle, with a valid strobe in the cycle after the request. A secure-burn request is answered one cycle later. The answer is either a write strobe with the data to program, or an error pulse that leaves the programmer outputs as they were.

Top module: `authmsg_assembler`

## Requirements
- R1: After a synchronous reset, every output is zero: msg_valid_o, msg_mfr_o, msg_sn_o, msg_secret_o, burn_wr_o, burn_err_o, burn_secret_o and burn_enbit_o.
- R2: msg_valid_o is 1 in exactly the cycle after each cycle with mac_req_i high, and 0 after every cycle with mac_req_i low.
- R3: With the guard burned (guard_unburned_i = 0), msg_mfr_o = {rom_mfr_i[15:0], fuse_mfr_i[7:0]}, with the ROM part in bits 23:8.
- R4: With the guard unburned (guard_unburned_i = 1), the fuse parts of the identity fields are all ones: msg_mfr_o[7:0] = 8'hFF. When the serial number is included, msg_sn_o[31:0] is also all ones. The ROM parts pass through unchanged.
- R5: msg_secret_o equals fuse_secret_i when the guard is burned, and 64'hFFFF_FFFF_FFFF_FFFF when it is unburned.
- R6: With use_sn_i = 1 and the guard burned, msg_sn_o = {rom_sn_i[15:0], fuse_sn_i[31:0]}, with the ROM part in bits 47:32.
- R7: With use_sn_i = 0, msg_sn_o is all zero, whatever the guard state.
- R8: A burn request (burn_req_i) made while the guard is unburned is accepted. In the next cycle burn_wr_o is 1 for one cycle, burn_err_o is 0, and burn_secret_o and burn_enbit_o carry the burn_secret_i and burn_enbit_i values of the request.
- R9: A burn request made while the guard is burned is rejected. In the next cycle burn_err_o is 1 for one cycle, burn_wr_o is 0, and burn_secret_o and burn_enbit_o keep their previous values.
- R10: In a cycle without mac_req_i, the message fields keep the values from the last request, even if the ROM or fuse inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rom_mfr_i | input | 16 | ROM part of the manufacturing ID |
| rom_sn_i | input | 16 | ROM part of the serial number |
| fuse_mfr_i | input | 8 | Fuse part of the manufacturing ID |
| fuse_sn_i | input | 32 | Fuse part of the serial number |
| fuse_secret_i | input | 64 | Secret fuse contents |
| guard_unburned_i | input | 1 | Guard fuse: 1 = unburned, 0 = burned |
| mac_req_i | input | 1 | Digest message request |
| use_sn_i | input | 1 | Include the serial number in this request |
| msg_valid_o | output | 1 | Message fields valid (one cycle) |
| msg_mfr_o | output | 24 | Manufacturing ID field |
| msg_sn_o | output | 48 | Serial number field |
| msg_secret_o | output | 64 | Secret fuse field |
| burn_req_i | input | 1 | Secure-burn request |
| burn_secret_i | input | 64 | Secret value to program |
| burn_enbit_i | input | 1 | Burn-enable bit value to program |
| burn_wr_o | output | 1 | Accepted burn strobe (one cycle) |
| burn_err_o | output | 1 | Rejected burn pulse (one cycle) |
| burn_secret_o | output | 64 | Secret value handed to the fuse programmer |
| burn_enbit_o | output | 1 | Burn-enable bit handed to the fuse programmer |

## Verification
Digest requests are swept over every combination of guard state and serial-number flag, and each combination is run with 64 data patterns. In the patterns a single one walks across the secret, a single zero walks across the fuse part of the serial number, and the ROM and manufacturing values are computed from the index. These patterns show whether masking covers every fuse bit, whether it leaves the ROM halves alone, and whether the zero fill of the serial slot wins over masking. Burn requests are tried in both guard states with distinct data. A rejected burn that follows an accepted one shows whether the programmer outputs really hold their value. Changing the inputs without a request shows whether the message register holds.

// File: rtl/authmsg_pkg.sv
package authmsg_pkg;

  typedef enum logic [1:0] {
    BV_IDLE   = 2'd0,
    BV_ACCEPT = 2'd1,
    BV_REJECT = 2'd2
  } burn_verdict_e;

endpackage

// File: rtl/fuse_field_gate.sv
module fuse_field_gate #(
  parameter int W = 8
) (
  input  logic         force_ones,
  input  logic [W-1:0] raw,
  output logic [W-1:0] gated
);

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      assign gated[b] = raw[b] | force_ones;
    end
  endgenerate

endmodule

// File: rtl/msg_pack.sv
module msg_pack #(
  parameter int MFR_ROM_W  = 16,
  parameter int MFR_FUSE_W = 8,
  parameter int SN_ROM_W   = 16,
  parameter int SN_FUSE_W  = 32,
  parameter int SECRET_W   = 64,
  localparam int MFR_W     = MFR_ROM_W + MFR_FUSE_W,
  localparam int SN_W      = SN_ROM_W + SN_FUSE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req,
  input  logic                  use_sn,
  input  logic [MFR_ROM_W-1:0]  rom_mfr,
  input  logic [SN_ROM_W-1:0]   rom_sn,
  input  logic [MFR_FUSE_W-1:0] g_mfr,
  input  logic [SN_FUSE_W-1:0]  g_sn,
  input  logic [SECRET_W-1:0]   g_secret,
  output logic                  valid,
  output logic [MFR_W-1:0]      mfr,
  output logic [SN_W-1:0]       sn,
  output logic [SECRET_W-1:0]   secret
);

  logic [SN_W-1:0] sn_next;

  always_comb begin
    if (use_sn) sn_next = {rom_sn, g_sn};
    else        sn_next = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      mfr    <= '0;
      sn     <= '0;
      secret <= '0;
    end else begin
      valid <= req;
      if (req) begin
        mfr    <= {rom_mfr, g_mfr};
        sn     <= sn_next;
        secret <= g_secret;
      end
    end
  end

endmodule

// File: rtl/burn_guard.sv
module burn_guard
  import authmsg_pkg::*;
#(
  parameter int SECRET_W = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                unburned,
  input  logic                req,
  input  logic [SECRET_W-1:0] secret_in,
  input  logic                enbit_in,
  output logic                wr,
  output logic                err,
  output logic [SECRET_W-1:0] secret_out,
  output logic                enbit_out
);

  burn_verdict_e verdict;

  always_comb begin
    if (!req)         verdict = BV_IDLE;
    else if (unburned) verdict = BV_ACCEPT;
    else              verdict = BV_REJECT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr         <= 1'b0;
      err        <= 1'b0;
      secret_out <= '0;
      enbit_out  <= 1'b0;
    end else begin
      wr  <= (verdict == BV_ACCEPT);
      err <= (verdict == BV_REJECT);
      if (verdict == BV_ACCEPT) begin
        secret_out <= secret_in;
        enbit_out  <= enbit_in;
      end
    end
  end

endmodule

// File: rtl/authmsg_assembler.sv
module authmsg_assembler #(
  parameter int MFR_ROM_W  = 16,
  parameter int MFR_FUSE_W = 8,
  parameter int SN_ROM_W   = 16,
  parameter int SN_FUSE_W  = 32,
  parameter int SECRET_W   = 64,
  localparam int MFR_W     = MFR_ROM_W + MFR_FUSE_W,
  localparam int SN_W      = SN_ROM_W + SN_FUSE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [MFR_ROM_W-1:0]  rom_mfr_i,
  input  logic [SN_ROM_W-1:0]   rom_sn_i,
  input  logic [MFR_FUSE_W-1:0] fuse_mfr_i,
  input  logic [SN_FUSE_W-1:0]  fuse_sn_i,
  input  logic [SECRET_W-1:0]   fuse_secret_i,
  input  logic                  guard_unburned_i,
  input  logic                  mac_req_i,
  input  logic                  use_sn_i,
  output logic                  msg_valid_o,
  output logic [MFR_W-1:0]      msg_mfr_o,
  output logic [SN_W-1:0]       msg_sn_o,
  output logic [SECRET_W-1:0]   msg_secret_o,
  input  logic                  burn_req_i,
  input  logic [SECRET_W-1:0]   burn_secret_i,
  input  logic                  burn_enbit_i,
  output logic                  burn_wr_o,
  output logic                  burn_err_o,
  output logic [SECRET_W-1:0]   burn_secret_o,
  output logic                  burn_enbit_o
);

  logic [MFR_FUSE_W-1:0] g_mfr;
  logic [SN_FUSE_W-1:0]  g_sn;
  logic [SECRET_W-1:0]   g_secret;

  fuse_field_gate #(.W(MFR_FUSE_W)) u_gate_mfr (
    .force_ones(guard_unburned_i), .raw(fuse_mfr_i), .gated(g_mfr));
  fuse_field_gate #(.W(SN_FUSE_W)) u_gate_sn (
    .force_ones(guard_unburned_i), .raw(fuse_sn_i), .gated(g_sn));
  fuse_field_gate #(.W(SECRET_W)) u_gate_secret (
    .force_ones(guard_unburned_i), .raw(fuse_secret_i), .gated(g_secret));

  msg_pack #(
    .MFR_ROM_W(MFR_ROM_W), .MFR_FUSE_W(MFR_FUSE_W),
    .SN_ROM_W(SN_ROM_W), .SN_FUSE_W(SN_FUSE_W), .SECRET_W(SECRET_W)
  ) u_pack (
    .clk(clk), .rst(rst), .req(mac_req_i), .use_sn(use_sn_i),
    .rom_mfr(rom_mfr_i), .rom_sn(rom_sn_i),
    .g_mfr(g_mfr), .g_sn(g_sn), .g_secret(g_secret),
    .valid(msg_valid_o), .mfr(msg_mfr_o), .sn(msg_sn_o), .secret(msg_secret_o)
  );

  burn_guard #(.SECRET_W(SECRET_W)) u_guard (
    .clk(clk), .rst(rst), .unburned(guard_unburned_i), .req(burn_req_i),
    .secret_in(burn_secret_i), .enbit_in(burn_enbit_i),
    .wr(burn_wr_o), .err(burn_err_o),
    .secret_out(burn_secret_o), .enbit_out(burn_enbit_o)
  );

endmodule

// File: rtl/authmsg_assembler_chk.sv
module authmsg_assembler_chk #(
  parameter int MFR_ROM_W  = 16,
  parameter int MFR_FUSE_W = 8,
  parameter int SN_ROM_W   = 16,
  parameter int SN_FUSE_W  = 32,
  parameter int SECRET_W   = 64,
  localparam int MFR_W     = MFR_ROM_W + MFR_FUSE_W,
  localparam int SN_W      = SN_ROM_W + SN_FUSE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [MFR_ROM_W-1:0]  rom_mfr_i,
  input  logic [SN_ROM_W-1:0]   rom_sn_i,
  input  logic [MFR_FUSE_W-1:0] fuse_mfr_i,
  input  logic [SN_FUSE_W-1:0]  fuse_sn_i,
  input  logic [SECRET_W-1:0]   fuse_secret_i,
  input  logic                  guard_unburned_i,
  input  logic                  mac_req_i,
  input  logic                  use_sn_i,
  input  logic                  msg_valid_o,
  input  logic [MFR_W-1:0]      msg_mfr_o,
  input  logic [SN_W-1:0]       msg_sn_o,
  input  logic [SECRET_W-1:0]   msg_secret_o,
  input  logic                  burn_req_i,
  input  logic [SECRET_W-1:0]   burn_secret_i,
  input  logic                  burn_enbit_i,
  input  logic                  burn_wr_o,
  input  logic                  burn_err_o,
  input  logic [SECRET_W-1:0]   burn_secret_o,
  input  logic                  burn_enbit_o
);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    mac_req_i |=> msg_valid_o);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !mac_req_i |=> !msg_valid_o);
  assert_mfr_burned_R3: assert property (@(posedge clk) disable iff (rst)
    (mac_req_i && !guard_unburned_i) |=> msg_mfr_o == $past({rom_mfr_i, fuse_mfr_i}));
  assert_mfr_masked_R4: assert property (@(posedge clk) disable iff (rst)
    (mac_req_i && guard_unburned_i) |=>
      (msg_mfr_o[MFR_FUSE_W-1:0] == '1) && (msg_mfr_o[MFR_W-1:MFR_FUSE_W] == $past(rom_mfr_i)));
  assert_secret_masked_R5: assert property (@(posedge clk) disable iff (rst)
    (mac_req_i && guard_unburned_i) |=> msg_secret_o == '1);
  assert_secret_real_R5: assert property (@(posedge clk) disable iff (rst)
    (mac_req_i && !guard_unburned_i) |=> msg_secret_o == $past(fuse_secret_i));
  assert_sn_real_R6: assert property (@(posedge clk) disable iff (rst)
    (mac_req_i && use_sn_i && !guard_unburned_i) |=> msg_sn_o == $past({rom_sn_i, fuse_sn_i}));
  assert_sn_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (mac_req_i && !use_sn_i) |=> msg_sn_o == '0);
  assert_burn_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (burn_req_i && guard_unburned_i) |=>
      burn_wr_o && !burn_err_o && burn_secret_o == $past(burn_secret_i));
  assert_burn_reject_R9: assert property (@(posedge clk) disable iff (rst)
    (burn_req_i && !guard_unburned_i) |=>
      burn_err_o && !burn_wr_o && $stable(burn_secret_o) && $stable(burn_enbit_o));
  assert_burn_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(burn_wr_o && burn_err_o));
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !mac_req_i |=> $stable(msg_mfr_o) && $stable(msg_sn_o) && $stable(msg_secret_o));

endmodule

bind authmsg_assembler authmsg_assembler_chk #(
  .MFR_ROM_W(MFR_ROM_W), .MFR_FUSE_W(MFR_FUSE_W),
  .SN_ROM_W(SN_ROM_W), .SN_FUSE_W(SN_FUSE_W), .SECRET_W(SECRET_W)
) u_chk (.*);

// File: tb/sim_authmsg_assembler.sv
module sim_authmsg_assembler;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] rom_mfr_i = '0;
  logic [15:0] rom_sn_i = '0;
  logic [7:0]  fuse_mfr_i = '0;
  logic [31:0] fuse_sn_i = '0;
  logic [63:0] fuse_secret_i = '0;
  logic        guard_unburned_i = 1'b1;
  logic        mac_req_i = 1'b0;
  logic        use_sn_i = 1'b0;
  logic        msg_valid_o;
  logic [23:0] msg_mfr_o;
  logic [47:0] msg_sn_o;
  logic [63:0] msg_secret_o;
  logic        burn_req_i = 1'b0;
  logic [63:0] burn_secret_i = '0;
  logic        burn_enbit_i = 1'b0;
  logic        burn_wr_o;
  logic        burn_err_o;
  logic [63:0] burn_secret_o;
  logic        burn_enbit_o;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  authmsg_assembler u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] e_secret;
    logic [47:0] e_sn;
    logic [23:0] e_mfr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", 64'(msg_valid_o), 64'd0);
    chk("R1 mfr", 64'(msg_mfr_o), 64'd0);
    chk("R1 sn", 64'(msg_sn_o), 64'd0);
    chk("R1 secret", msg_secret_o, 64'd0);
    chk("R1 burn_wr", 64'(burn_wr_o), 64'd0);
    chk("R1 burn_err", 64'(burn_err_o), 64'd0);
    chk("R1 burn_secret", burn_secret_o, 64'd0);
    chk("R1 burn_enbit", 64'(burn_enbit_o), 64'd0);

    // Sweep: guard state x serial flag x 64 patterns
    for (int g = 0; g < 2; g++) begin
      for (int s = 0; s < 2; s++) begin
        for (int p = 0; p < 64; p++) begin
          guard_unburned_i = g[0];
          use_sn_i = s[0];
          fuse_secret_i = 64'd1 << p;
          fuse_sn_i = ~(32'd1 << (p % 32));
          fuse_mfr_i = 8'(p * 37 + 1);
          rom_mfr_i = 16'(p * 613 + 5);
          rom_sn_i = 16'(p * 977 + 3);
          mac_req_i = 1'b1;
          e_mfr = {rom_mfr_i, (g == 1) ? 8'hFF : fuse_mfr_i};
          e_sn = (s == 0) ? 48'd0 : {rom_sn_i, (g == 1) ? 32'hFFFF_FFFF : fuse_sn_i};
          e_secret = (g == 1) ? 64'hFFFF_FFFF_FFFF_FFFF : fuse_secret_i;
          @(negedge clk);
          chk("R2 valid after request", 64'(msg_valid_o), 64'd1);
          chk(g == 1 ? "R4 mfr masked" : "R3 mfr real", 64'(msg_mfr_o), 64'(e_mfr));
          chk(s == 0 ? "R7 sn zero" : (g == 1 ? "R4 sn masked" : "R6 sn real"),
              64'(msg_sn_o), 64'(e_sn));
          chk("R5 secret", msg_secret_o, e_secret);
          mac_req_i = 1'b0;
          // R10: inputs change without a request
          fuse_secret_i = ~fuse_secret_i;
          fuse_sn_i = ~fuse_sn_i;
          rom_mfr_i = ~rom_mfr_i;
          use_sn_i = ~use_sn_i;
          guard_unburned_i = ~guard_unburned_i;
          @(negedge clk);
          chk("R2 valid idle", 64'(msg_valid_o), 64'd0);
          chk("R10 hold mfr", 64'(msg_mfr_o), 64'(e_mfr));
          chk("R10 hold sn", 64'(msg_sn_o), 64'(e_sn));
          chk("R10 hold secret", msg_secret_o, e_secret);
        end
      end
    end

    // R8: accepted burn while unburned
    guard_unburned_i = 1'b1;
    burn_req_i = 1'b1;
    burn_secret_i = 64'hA5A5_0123_4567_89AB;
    burn_enbit_i = 1'b1;
    @(negedge clk);
    chk("R8 burn_wr", 64'(burn_wr_o), 64'd1);
    chk("R8 burn_err", 64'(burn_err_o), 64'd0);
    chk("R8 burn_secret", burn_secret_o, 64'hA5A5_0123_4567_89AB);
    chk("R8 burn_enbit", 64'(burn_enbit_o), 64'd1);
    burn_req_i = 1'b0;
    @(negedge clk);
    chk("R8 burn_wr one cycle", 64'(burn_wr_o), 64'd0);

    // R9: rejected burn once the guard is burned
    guard_unburned_i = 1'b0;
    burn_req_i = 1'b1;
    burn_secret_i = 64'h0F0F_F0F0_1111_2222;
    burn_enbit_i = 1'b0;
    @(negedge clk);
    chk("R9 burn_err", 64'(burn_err_o), 64'd1);
    chk("R9 burn_wr", 64'(burn_wr_o), 64'd0);
    chk("R9 burn_secret held", burn_secret_o, 64'hA5A5_0123_4567_89AB);
    chk("R9 burn_enbit held", 64'(burn_enbit_o), 64'd1);
    burn_req_i = 1'b0;
    @(negedge clk);
    chk("R9 burn_err one cycle", 64'(burn_err_o), 64'd0);
    chk("R9 burn_secret still held", burn_secret_o, 64'hA5A5_0123_4567_89AB);

    // R8 again with different data, then R1 by a second reset
    guard_unburned_i = 1'b1;
    burn_req_i = 1'b1;
    burn_secret_i = 64'h1;
    burn_enbit_i = 1'b0;
    @(negedge clk);
    chk("R8 burn_secret second", burn_secret_o, 64'h1);
    chk("R8 burn_enbit second", 64'(burn_enbit_o), 64'd0);
    burn_req_i = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 burn_secret after reset", burn_secret_o, 64'd0);
    chk("R1 secret after reset", msg_secret_o, 64'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule